// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the status word of a 16-bit accumulator-style processor core. The word holds eight single-bit condition and mode flags and a 3-bit interrupt priority field, 11 bits of state in all. The flags are written by the arithmetic unit through per-flag write enables. They are also written by explicit set and clear commands, which can name one flag or any group of the eight flags through a mask. The interrupt-disable flag is also forced to 1 whenever an interrupt is accepted, and reset places the word in a defined start state.

The decoder, the arithmetic unit and the interrupt controller lie outside the block and drive its command inputs directly. Every update takes effect at the rising clock edge and shows on the outputs from the next cycle on. The whole word is offered as a 16-bit read value whose top five bits are always zero, and each field also has an output of its own.

Top module: `cpu_status_word`

## Requirements
- R1: The 16-bit read value carries carry in bit 0, zero in bit 1, interrupt disable in bit 2, decimal mode in bit 3, index-narrow in bit 4, data-narrow in bit 5, overflow in bit 6, negative in bit 7 and the priority field in bits 10:8. Bits 15:11 always read 0. Each single-field output equals its bit in the read value.
- R2: A synchronous active-high reset leaves the read value at 0x0004 on the next cycle: interrupt disable is 1, and every other flag and the priority field are 0.
- R3: The arithmetic unit writes flags through a 4-bit enable and a 4-bit result. Enable bit 0 writes carry, bit 1 writes zero, bit 2 writes overflow and bit 3 writes negative, each with the matching result bit. Flags whose enable is 0 keep their value.
- R4: Every flag selected by a 1 in the 8-bit set mask (mask bit n targets read bit n) is 1 after the edge.
- R5: Every flag selected by a 1 in the 8-bit clear mask is 0 after the edge. When the set and clear masks select the same bit, the set wins.
- R6: The single carry-set input makes carry 1 and the single carry-clear input makes it 0. When both are asserted, the set wins.
- R7: The single interrupt-disable set input makes that flag 1 and the clear input makes it 0. When both are asserted, the set wins.
- R8: When an explicit set or clear (mask or single) targets a flag in the same cycle as an arithmetic-unit write to it, the explicit command decides the flag's value.
- R9: An interrupt-accepted pulse leaves interrupt disable at 1 after the edge, even if a clear command targets it in the same cycle.
- R10: The priority load input copies the 3-bit priority input into bits 10:8. The masks and the other commands leave the priority field unchanged.
- R11: In a cycle with no reset and no command active, the read value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alu_we_i | input | 4 | Arithmetic-unit write enables: bit 0 carry, bit 1 zero, bit 2 overflow, bit 3 negative |
| alu_res_i | input | 4 | Arithmetic-unit flag values, same bit order as alu_we_i |
| set_mask_i | input | 8 | Flags to set, bit n targets read bit n |
| clr_mask_i | input | 8 | Flags to clear, bit n targets read bit n |
| carry_set_i | input | 1 | Set the carry flag |
| carry_clr_i | input | 1 | Clear the carry flag |
| imask_set_i | input | 1 | Set the interrupt-disable flag |
| imask_clr_i | input | 1 | Clear the interrupt-disable flag |
| irq_ack_i | input | 1 | Interrupt accepted, forces interrupt disable to 1 |
| prio_load_i | input | 1 | Load the priority field |
| prio_i | input | 3 | New priority value |
| rd_data_o | output | 16 | Status word, bits 15:11 zero |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| imask_o | output | 1 | Interrupt-disable flag |
| dec_o | output | 1 | Decimal mode flag |
| idx8_o | output | 1 | Index registers narrow (8-bit) when 1 |
| dat8_o | output | 1 | Data narrow (8-bit) when 1 |
| ovf_o | output | 1 | Overflow flag |
| neg_o | output | 1 | Negative flag |
| prio_o | output | 3 | Interrupt priority field |

## Verification
The bench applies every set mask against a spread of clear masks and starting words, so it catches a mask wired to the wrong bit and a set/clear overlap resolved the wrong way round. It also applies every combination of arithmetic-unit enables and results. A design that mapped the enables to the wrong flags, or that let a disabled enable write its flag, would show a wrong bit there. The four single commands are crossed with simultaneous arithmetic writes, interrupt acceptance and a full clear mask. This exposes a design where the arithmetic unit overrides an explicit command or where a clear defeats the interrupt-forced disable bit. Priority loads, idle cycles and a reset in the middle of the run confirm that the priority field is separate from the masks, that the word holds when nothing is active, and that the reset word is 0x0004.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;

    // Field widths of the status word
    localparam int FLAG_W = 8;
    localparam int PRIO_W = 3;
    localparam int ALU_W  = 4;
    localparam int STAT_W = FLAG_W + PRIO_W;

    // Flag bit positions (decoded by neighbouring logic)
    localparam int B_C = 0;
    localparam int B_Z = 1;
    localparam int B_I = 2;
    localparam int B_D = 3;
    localparam int B_X = 4;
    localparam int B_M = 5;
    localparam int B_V = 6;
    localparam int B_N = 7;

    typedef struct packed {
        logic neg;
        logic ovf;
        logic dat_narrow;
        logic idx_narrow;
        logic dec_mode;
        logic irq_mask;
        logic zero;
        logic carry;
    } flags_t;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        flags_t            flags;
    } status_t;

    // Only interrupt disable comes up set
    localparam flags_t FLAGS_RST = '{neg: 1'b0, ovf: 1'b0, dat_narrow: 1'b0,
                                     idx_narrow: 1'b0, dec_mode: 1'b0,
                                     irq_mask: 1'b1, zero: 1'b0, carry: 1'b0};

    // Flag position written by each arithmetic-unit enable bit
    function automatic int alu_pos(input int idx);
        case (idx)
            0:       return B_C;
            1:       return B_Z;
            2:       return B_V;
            default: return B_N;
        endcase
    endfunction

    // One-hot vector for a single flag command
    function automatic logic [FLAG_W-1:0] one_flag(input logic en, input int pos);
        logic [FLAG_W-1:0] v;
        v      = '0;
        v[pos] = en;
        return v;
    endfunction

endpackage

// File: rtl/status_alu_merge.sv
module status_alu_merge
    import cpu_status_pkg::*;
(
    input  logic [FLAG_W-1:0] cur_i,
    input  logic [ALU_W-1:0]  we_i,
    input  logic [ALU_W-1:0]  res_i,
    output logic [FLAG_W-1:0] merged_o
);
    // Mark, per flag bit, whether an ALU lane writes it and with what value
    logic [FLAG_W-1:0] hit;
    logic [FLAG_W-1:0] val;

    always_comb begin
        hit = '0;
        val = '0;
        for (int i = 0; i < ALU_W; i++) begin
            hit[alu_pos(i)] = we_i[i];
            val[alu_pos(i)] = res_i[i];
        end
    end

    generate
        for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
            assign merged_o[b] = hit[b] ? val[b] : cur_i[b];
        end
    endgenerate

endmodule

// File: rtl/status_cmd_apply.sv
module status_cmd_apply
    import cpu_status_pkg::*;
(
    input  logic [FLAG_W-1:0] base_i,
    input  logic [FLAG_W-1:0] set_mask_i,
    input  logic [FLAG_W-1:0] clr_mask_i,
    input  logic              carry_set_i,
    input  logic              carry_clr_i,
    input  logic              imask_set_i,
    input  logic              imask_clr_i,
    input  logic              irq_ack_i,
    output logic [FLAG_W-1:0] next_o
);
    logic [FLAG_W-1:0] set_all;
    logic [FLAG_W-1:0] clr_all;
    logic [FLAG_W-1:0] force_on;

    assign set_all  = set_mask_i | one_flag(carry_set_i, B_C) | one_flag(imask_set_i, B_I);
    assign clr_all  = clr_mask_i | one_flag(carry_clr_i, B_C) | one_flag(imask_clr_i, B_I);
    assign force_on = one_flag(irq_ack_i, B_I);

    // clear first, then set, then interrupt forcing on top
    assign next_o = ((base_i & ~clr_all) | set_all) | force_on;

endmodule

// File: rtl/status_read_view.sv
module status_read_view
    import cpu_status_pkg::*;
#(
    parameter int VIEW_W = 16
) (
    input  status_t           st_i,
    output logic [VIEW_W-1:0] rd_o
);
    generate
        if (VIEW_W > STAT_W) begin : g_pad
            assign rd_o = {{(VIEW_W - STAT_W){1'b0}}, st_i};
        end else begin : g_cut
            assign rd_o = st_i[VIEW_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/cpu_status_word.sv
module cpu_status_word
    import cpu_status_pkg::*;
#(
    parameter int VIEW_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        alu_we_i,
    input  logic [3:0]        alu_res_i,
    input  logic [7:0]        set_mask_i,
    input  logic [7:0]        clr_mask_i,
    input  logic              carry_set_i,
    input  logic              carry_clr_i,
    input  logic              imask_set_i,
    input  logic              imask_clr_i,
    input  logic              irq_ack_i,
    input  logic              prio_load_i,
    input  logic [2:0]        prio_i,
    output logic [VIEW_W-1:0] rd_data_o,
    output logic              carry_o,
    output logic              zero_o,
    output logic              imask_o,
    output logic              dec_o,
    output logic              idx8_o,
    output logic              dat8_o,
    output logic              ovf_o,
    output logic              neg_o,
    output logic [2:0]        prio_o
);
    status_t           state_q;
    logic [FLAG_W-1:0] alu_merged;
    logic [FLAG_W-1:0] flags_next;

    // ALU update first; explicit commands applied over it
    status_alu_merge u_alu (
        .cur_i    (state_q.flags),
        .we_i     (alu_we_i),
        .res_i    (alu_res_i),
        .merged_o (alu_merged)
    );

    status_cmd_apply u_cmd (
        .base_i      (alu_merged),
        .set_mask_i  (set_mask_i),
        .clr_mask_i  (clr_mask_i),
        .carry_set_i (carry_set_i),
        .carry_clr_i (carry_clr_i),
        .imask_set_i (imask_set_i),
        .imask_clr_i (imask_clr_i),
        .irq_ack_i   (irq_ack_i),
        .next_o      (flags_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.flags <= FLAGS_RST;
            state_q.prio  <= '0;
        end else begin
            state_q.flags <= flags_t'(flags_next);
            if (prio_load_i) begin
                state_q.prio <= prio_i;
            end
        end
    end

    status_read_view #(.VIEW_W(VIEW_W)) u_view (
        .st_i (state_q),
        .rd_o (rd_data_o)
    );

    assign carry_o = state_q.flags.carry;
    assign zero_o  = state_q.flags.zero;
    assign imask_o = state_q.flags.irq_mask;
    assign dec_o   = state_q.flags.dec_mode;
    assign idx8_o  = state_q.flags.idx_narrow;
    assign dat8_o  = state_q.flags.dat_narrow;
    assign ovf_o   = state_q.flags.ovf;
    assign neg_o   = state_q.flags.neg;
    assign prio_o  = state_q.prio;

endmodule

// File: rtl/cpu_status_word_chk.sv
module cpu_status_word_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  alu_we_i,
    input logic [3:0]  alu_res_i,
    input logic [7:0]  set_mask_i,
    input logic [7:0]  clr_mask_i,
    input logic        carry_set_i,
    input logic        carry_clr_i,
    input logic        imask_set_i,
    input logic        imask_clr_i,
    input logic        irq_ack_i,
    input logic        prio_load_i,
    input logic [2:0]  prio_i,
    input logic [15:0] rd_data_o,
    input logic        carry_o,
    input logic [2:0]  prio_o
);
    logic idle;
    assign idle = !rst && (alu_we_i == '0) && (set_mask_i == '0) && (clr_mask_i == '0)
               && !carry_set_i && !carry_clr_i && !imask_set_i && !imask_clr_i
               && !irq_ack_i && !prio_load_i;

    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[15:11] == 5'b0);

    // R2
    reset_word_chk: assert property (@(posedge clk)
        rst |=> rd_data_o == 16'h0004);

    // R3
    alu_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_we_i[0] && !set_mask_i[0] && !clr_mask_i[0] && !carry_set_i && !carry_clr_i)
        |=> carry_o == $past(alu_res_i[0]));

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_mask_i != 8'h00) |=> ((rd_data_o[7:0] & $past(set_mask_i)) == $past(set_mask_i)));

    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_ack_i && !carry_set_i && !imask_set_i)
        |=> ((rd_data_o[7:0] & $past(clr_mask_i & ~set_mask_i)) == 8'h00));

    // R9
    irq_force_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack_i |=> rd_data_o[2]);

    // R10
    prio_load_chk: assert property (@(posedge clk) disable iff (rst)
        prio_load_i |=> prio_o == $past(prio_i));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        idle |=> $stable(rd_data_o));

endmodule

bind cpu_status_word cpu_status_word_chk u_chk (.*);

// File: tb/cpu_status_word_tb.sv
`timescale 1ns/1ps
module cpu_status_word_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  alu_we_i, alu_res_i;
    logic [7:0]  set_mask_i, clr_mask_i;
    logic        carry_set_i, carry_clr_i, imask_set_i, imask_clr_i;
    logic        irq_ack_i, prio_load_i;
    logic [2:0]  prio_i;
    logic [15:0] rd_data_o;
    logic        carry_o, zero_o, imask_o, dec_o, idx8_o, dat8_o, ovf_o, neg_o;
    logic [2:0]  prio_o;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [10:0] exp_q  = 11'h004;

    always #2.5 clk = ~clk;

    cpu_status_word u_dut (.*);

    task automatic idle_in();
        rst = 1'b0; alu_we_i = '0; alu_res_i = '0; set_mask_i = '0; clr_mask_i = '0;
        carry_set_i = 1'b0; carry_clr_i = 1'b0; imask_set_i = 1'b0; imask_clr_i = 1'b0;
        irq_ack_i = 1'b0; prio_load_i = 1'b0; prio_i = '0;
    endtask

    // Expected next word from the requirement text, then one clock and compare
    task automatic step(input string tag);
        logic [7:0]  f, s, c;
        logic [15:0] want, got_bits;
        if (rst) begin
            exp_q = 11'h004;
        end else begin
            f = exp_q[7:0];
            if (alu_we_i[0]) f[0] = alu_res_i[0];
            if (alu_we_i[1]) f[1] = alu_res_i[1];
            if (alu_we_i[2]) f[6] = alu_res_i[2];
            if (alu_we_i[3]) f[7] = alu_res_i[3];
            s = set_mask_i | {5'b0, imask_set_i, 1'b0, carry_set_i};
            c = clr_mask_i | {5'b0, imask_clr_i, 1'b0, carry_clr_i};
            f = (f & ~c) | s;
            if (irq_ack_i) f[2] = 1'b1;
            exp_q = {prio_load_i ? prio_i : exp_q[10:8], f};
        end
        @(posedge clk);
        #1;
        want     = {5'b0, exp_q};
        got_bits = {5'b0, prio_o, neg_o, ovf_o, dat8_o, idx8_o, dec_o, imask_o, zero_o, carry_o};
        n_chk++;
        if (rd_data_o !== want) begin
            n_fail++;
            $display("FAIL %s: rd_data_o actual %h expected %h", tag, rd_data_o, want);
        end
        n_chk++;
        if (got_bits !== want) begin
            n_fail++;
            $display("FAIL R1: field outputs actual %h expected %h", got_bits, want);
        end
    endtask

    // Bring the word to an exact value through the masks and the priority load
    task automatic load(input logic [7:0] v, input logic [2:0] p);
        idle_in();
        set_mask_i = v; clr_mask_i = ~v; prio_load_i = 1'b1; prio_i = p;
        step("R4");
        idle_in();
    endtask

    initial begin
        idle_in();
        rst = 1'b1;
        step("R2");
        step("R2");
        idle_in();
        step("R11");

        // R4 / R5: all set masks against varied clear masks and bases
        for (int s = 0; s < 256; s++) begin
            for (int k = 0; k < 8; k++) begin
                load(8'((s * 29 + k * 71) ^ 8'h5A), 3'(k));
                set_mask_i = 8'(s);
                clr_mask_i = 8'((s * 37 + k * 53) ^ (k * 17));
                step("R5");
            end
        end

        // R3: every enable/result combination
        for (int w = 0; w < 16; w++) begin
            for (int r = 0; r < 16; r++) begin
                load(8'((w * 16 + r) ^ 8'hA5), 3'(r));
                alu_we_i  = 4'(w);
                alu_res_i = 4'(r);
                step("R3");
            end
        end

        // R6 R7 R8 R9: single commands crossed with ALU writes, interrupt, full clear
        for (int m = 0; m < 16; m++) begin
            for (int v = 0; v < 8; v++) begin
                load(v[0] ? 8'hFF : 8'h00, 3'd5);
                carry_set_i = m[0]; carry_clr_i = m[1];
                imask_set_i = m[2]; imask_clr_i = m[3];
                alu_we_i    = 4'hF;
                alu_res_i   = v[0] ? 4'h0 : 4'hF;
                irq_ack_i   = v[1];
                clr_mask_i  = v[2] ? 8'hFF : 8'h00;
                if (v[1])      step("R9");
                else if (m[1:0] != 0) step("R6");
                else if (m[3:2] != 0) step("R7");
                else           step("R8");
            end
        end

        // R10: priority load and mask isolation
        for (int p = 0; p < 8; p++) begin
            idle_in();
            prio_load_i = 1'b1; prio_i = 3'(p); set_mask_i = 8'hFF;
            step("R10");
            idle_in();
            clr_mask_i = 8'hFF; set_mask_i = 8'(p);
            step("R10");
        end

        // R11: idle holds
        load(8'hC3, 3'd6);
        for (int i = 0; i < 4; i++) step("R11");

        // R2 again mid-run
        rst = 1'b1;
        step("R2");
        idle_in();
        step("R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule